// File: doc/BRIEF.md
# Port-Driven Memory Bank Mapper

This block sits between an 8-bit CPU with a 64 KB address space and the memories behind it. For every memory address it reports which physical source a read should come from and at which offset inside that source. The sources are BASIC ROM, kanji ROM, voice ROM, the two 8 KB cartridge halves, the character ROM, internal RAM, extended RAM, and an empty area. For writes it reports the same information, together with a gate that allows or blocks the write strobe. The memory arrays are outside the block. They only see the tagged address it produces.

Reads are steered per 8 KB page. Each half of a read-configuration port selects what sits in one pair of pages, using a 16-entry code table. The table includes mixed pairs, so one page of a pair can come from one ROM and its neighbour from another. Writes are steered per 16 KB region by a separate enable port. A fourth port chooses the active kanji half and can lay voice ROM over pages 2 and 3. An external character-select pin forces page 3 onto the character ROM.

The pin is tracked by a two-state machine:
- `CHR_IDLE` moves to `CHR_FORCED` on the transition *pin fall*, which is a low level sampled while the previous sample was high.
- `CHR_FORCED` returns to `CHR_IDLE` on the transition *pin rise*.

The mapping itself is held as a resolved table, with one entry per page. The table changes only on the clock edges named in the requirements.

Top module: `bankmap_mapper`

## Requirements
- R1: After reset:
  - Port 0xF0 reads 0x11 and port 0xF1 reads 0xDD.
  - Pages 0–3 read BASIC at offsets 0x0000–0x7FFF.
  - Pages 4–7 read RAM at the matching address.
  - Writes are gated off in 16 KB regions 0–1 and allowed to RAM in regions 2–3.
- R2: The read page is address bits 15:13. Each page holds a source code and an 8 KB segment number, and `rd_off` = segment·0x2000 + address bits 12:0. The source codes are: 0 empty, 1 BASIC, 2 kanji, 3 voice, 4 cartridge half 1, 5 cartridge half 2, 6 character ROM, 7 RAM, 8 extended RAM.
- R3: A nibble code gives the pair (lower page, upper page) as follows. "K" is the current kanji half, "B" is BASIC, "c1" and "c2" are the cartridge halves, and a cartridge half always starts at offset 0.
  - 0 and F: empty, empty.
  - 1: B, B. 2: K, K. 3: c2, c2. 4: c1, c1.
  - 5: K, B. 6: B, K. 7: c1, c2. 8: c2, c1.
  - 9: c2, B. A: B, c2. B: c1, K. C: K, c1.
  - The low nibble of 0xF0 sets pages 0–1 and the low nibble of 0xF1 sets pages 4–5, with BASIC at 0x0000/0x2000.
- R4: In the high nibble of 0xF0 (pages 2–3), every kanji entry becomes voice ROM at 0x0000/0x2000. In the high nibble of 0xF1 (pages 6–7), kanji stays kanji. In both high nibbles, BASIC sits at 0x4000/0x6000.
- R5: Code D maps a pair to RAM at the same address as the CPU address. Code E maps it to extended RAM at the same address when extended RAM is fitted, and to empty otherwise.
- R6: Port 0xF2 sets the write mode of each region from two bits. Region r (address bits 15:14) takes its enable from bit 2r and its extended-RAM redirect from bit 2r+1, and the redirect wins when extended RAM is fitted. In an enabled region, `wr_src` is 7 or 8, `wr_off` equals the address, and `wr_gate` equals `mem_wr`.
- R7: In a region whose write mode is off, `wr_gate` stays low and `wr_src` reads 0, so the write is dropped with no error indication.
- R8: Bit 1 of port 0xC2 selects the upper 16 KB of kanji ROM (segments 2–3) as the current kanji half. Pages already mapped keep their old kanji segment until their port is written again.
- R9: Writing 0xC2 with bit 0 = 0 maps page 2 to voice 0x0000 unless it holds BASIC 0x4000. It likewise maps page 3 to voice 0x2000 unless it holds BASIC 0x6000.
- R10: Writing 0xC2 with bit 0 = 1 re-decodes the stored 0xF0 value, using the new kanji half.
- R11: When the pin falls, page 3 reads the character ROM at segment 0. While the machine is in `CHR_FORCED`, any re-decode of 0xF0 still leaves page 3 on the character ROM.
- R12: When the pin rises, the forced state clears and the stored 0xF0 value is re-decoded onto pages 0–3.
- R13: Reading port 0xF0 or 0xF1 returns the last byte written to it. Any other port reads 0xFF.
- R14: Port writes take effect at the clock edge that samples `io_wr`. A memory access in the same cycle still sees the old mapping, and the mapping does not change in a cycle with no port write and no pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for `io_addr` |
| chr_sel_n | input | 1 | Character-ROM select pin, active low |
| mem_addr | input | 16 | CPU memory address |
| mem_wr | input | 1 | CPU memory write request |
| rd_src | output | 4 | Source code for a read at `mem_addr` |
| rd_off | output | 16 | Offset inside the read source |
| wr_src | output | 4 | Source code for a write at `mem_addr` |
| wr_off | output | 16 | Offset inside the write source |
| wr_gate | output | 1 | Write strobe allowed to reach the source |

## Verification
The assertions cover behaviour that holds every cycle:
- A value written to 0xF0 is held as written.
- A write-mode byte of zero shuts the write gate.
- A pin fall always lands page 3 on the character ROM, and a pin rise always takes it off.
- The page table stays frozen in any cycle with no port write and no pin change.

Only the bench scenarios can show the rest. This includes the per-code contents of each page pair, the voice substitution that applies in one nibble but not the others, and the per-page exception in the voice overlay. It also includes the way a kanji-half change reaches a page only on re-decode, and the same-cycle ordering between a port write and a memory access.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int SEG_W = 3;

    typedef enum logic [3:0] {
        SRC_EMPTY = 4'd0,
        SRC_BASIC = 4'd1,
        SRC_KANJI = 4'd2,
        SRC_VOICE = 4'd3,
        SRC_CART1 = 4'd4,
        SRC_CART2 = 4'd5,
        SRC_CHAR  = 4'd6,
        SRC_RAM   = 4'd7,
        SRC_XRAM  = 4'd8
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [SEG_W-1:0] seg;
    } page_t;

    typedef enum logic [1:0] {
        WM_OFF  = 2'd0,
        WM_RAM  = 2'd1,
        WM_XRAM = 2'd2
    } wmode_e;

    typedef enum logic {
        CHR_IDLE   = 1'b0,
        CHR_FORCED = 1'b1
    } chr_state_e;

    function automatic page_t mk_page(src_e s, logic [SEG_W-1:0] g);
        page_t p;
        p.src = s;
        p.seg = g;
        return p;
    endfunction

endpackage

// File: rtl/bankmap_nibble_dec.sv
module bankmap_nibble_dec
    import bankmap_pkg::*;
#(
    parameter int PAIR       = 0,
    parameter bit EXT_FITTED = 1'b1
) (
    input  logic [3:0] code,
    input  logic       kbank,
    output page_t      pg_lo,
    output page_t      pg_hi
);
    // Pair 1 (pages 2-3) substitutes voice ROM for kanji.
    localparam bit VOICE_SUB = (PAIR == 1);
    // Odd pairs see the upper half of BASIC.
    localparam logic [SEG_W-1:0] BAS_SEG = (PAIR % 2 == 1) ? 3'd2 : 3'd0;
    // RAM and extended RAM follow the CPU address.
    localparam logic [SEG_W-1:0] RAM_SEG = SEG_W'(2 * PAIR);
    localparam src_e K_SRC = VOICE_SUB ? SRC_VOICE : SRC_KANJI;

    logic [SEG_W-1:0] k_seg;
    page_t bas_lo, bas_hi, k_lo, k_hi, c1, c2, nil, ram_lo, ram_hi, xr_lo, xr_hi;

    always_comb begin
        k_seg  = VOICE_SUB ? 3'd0 : {1'b0, kbank, 1'b0};
        bas_lo = mk_page(SRC_BASIC, BAS_SEG);
        bas_hi = mk_page(SRC_BASIC, BAS_SEG | 3'd1);
        k_lo   = mk_page(K_SRC, k_seg);
        k_hi   = mk_page(K_SRC, k_seg | 3'd1);
        c1     = mk_page(SRC_CART1, 3'd0);
        c2     = mk_page(SRC_CART2, 3'd0);
        nil    = mk_page(SRC_EMPTY, 3'd0);
        ram_lo = mk_page(SRC_RAM, RAM_SEG);
        ram_hi = mk_page(SRC_RAM, RAM_SEG | 3'd1);
        xr_lo  = EXT_FITTED ? mk_page(SRC_XRAM, RAM_SEG) : nil;
        xr_hi  = EXT_FITTED ? mk_page(SRC_XRAM, RAM_SEG | 3'd1) : nil;
    end

    always_comb begin
        unique case (code)
            4'h0: begin pg_lo = nil;    pg_hi = nil;    end
            4'h1: begin pg_lo = bas_lo; pg_hi = bas_hi; end
            4'h2: begin pg_lo = k_lo;   pg_hi = k_hi;   end
            4'h3: begin pg_lo = c2;     pg_hi = c2;     end
            4'h4: begin pg_lo = c1;     pg_hi = c1;     end
            4'h5: begin pg_lo = k_lo;   pg_hi = bas_hi; end
            4'h6: begin pg_lo = bas_lo; pg_hi = k_hi;   end
            4'h7: begin pg_lo = c1;     pg_hi = c2;     end
            4'h8: begin pg_lo = c2;     pg_hi = c1;     end
            4'h9: begin pg_lo = c2;     pg_hi = bas_hi; end
            4'hA: begin pg_lo = bas_lo; pg_hi = c2;     end
            4'hB: begin pg_lo = c1;     pg_hi = k_hi;   end
            4'hC: begin pg_lo = k_lo;   pg_hi = c1;     end
            4'hD: begin pg_lo = ram_lo; pg_hi = ram_hi; end
            4'hE: begin pg_lo = xr_lo;  pg_hi = xr_hi;  end
            4'hF: begin pg_lo = nil;    pg_hi = nil;    end
        endcase
    end

endmodule

// File: rtl/bankmap_char_fsm.sv
module bankmap_char_fsm
    import bankmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic forced,
    output logic set_evt,
    output logic clr_evt
);
    chr_state_e state_q, state_nx;
    logic       pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHR_IDLE;
            pin_q   <= 1'b1;
        end else begin
            state_q <= state_nx;
            pin_q   <= pin_n;
        end
    end

    always_comb begin
        state_nx = state_q;
        set_evt  = 1'b0;
        clr_evt  = 1'b0;
        unique case (state_q)
            CHR_IDLE: begin
                if (pin_q && !pin_n) begin
                    state_nx = CHR_FORCED;
                    set_evt  = 1'b1;
                end
            end
            CHR_FORCED: begin
                if (!pin_q && pin_n) begin
                    state_nx = CHR_IDLE;
                    clr_evt  = 1'b1;
                end
            end
        endcase
    end

    assign forced = (state_q == CHR_FORCED);

endmodule

// File: rtl/bankmap_wr_ctrl.sv
module bankmap_wr_ctrl
    import bankmap_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter bit         EXT_FITTED = 1'b1,
    parameter logic [7:0] P_WR_EN    = 8'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wr,
    output logic [3:0]        wr_src,
    output logic [ADDR_W-1:0] wr_off,
    output logic              wr_gate
);
    localparam int RGN_W   = 2;
    localparam int REGIONS = 1 << RGN_W;

    wmode_e mode_q  [REGIONS];
    wmode_e mode_nx [REGIONS];
    wmode_e cur;
    logic   upd;

    assign upd = io_wr && (io_addr == P_WR_EN);

    for (genvar r = 0; r < REGIONS; r++) begin : g_rgn
        assign mode_nx[r] = (EXT_FITTED && io_wdata[2*r+1]) ? WM_XRAM :
                            io_wdata[2*r]                   ? WM_RAM  : WM_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < REGIONS; r++) mode_q[r] <= (r >= 2) ? WM_RAM : WM_OFF;
        end else if (upd) begin
            for (int r = 0; r < REGIONS; r++) mode_q[r] <= mode_nx[r];
        end
    end

    assign cur = mode_q[mem_addr[ADDR_W-1 -: RGN_W]];

    always_comb begin
        wr_off  = mem_addr;
        wr_src  = SRC_EMPTY;
        wr_gate = 1'b0;
        unique case (cur)
            WM_RAM:  begin wr_src = SRC_RAM;  wr_gate = mem_wr; end
            WM_XRAM: begin wr_src = SRC_XRAM; wr_gate = mem_wr; end
            default: begin wr_src = SRC_EMPTY; wr_gate = 1'b0;  end
        endcase
    end

endmodule

// File: rtl/bankmap_mapper.sv
module bankmap_mapper
    import bankmap_pkg::*;
#(
    parameter int         ADDR_W         = 16,
    parameter bit         EXT_RAM_FITTED = 1'b1,
    parameter logic [7:0] P_RD_LO        = 8'hF0,
    parameter logic [7:0] P_RD_HI        = 8'hF1,
    parameter logic [7:0] P_WR_EN        = 8'hF2,
    parameter logic [7:0] P_ROM_SEL      = 8'hC2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              chr_sel_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wr,
    output logic [3:0]        rd_src,
    output logic [ADDR_W-1:0] rd_off,
    output logic [3:0]        wr_src,
    output logic [ADDR_W-1:0] wr_off,
    output logic              wr_gate
);
    localparam int PAGE_W   = 3;
    localparam int PAGES    = 1 << PAGE_W;
    localparam int PAIRS    = PAGES / 2;
    localparam int LO_PAGES = PAGES / 2;
    localparam int OFF_W    = ADDR_W - PAGE_W;
    localparam logic [7:0] LO_RST = 8'h11;
    localparam logic [7:0] HI_RST = 8'hDD;

    logic [7:0]            f0_q, f1_q, f0_src;
    logic                  kbank_q, kbank_nx;
    page_t [PAGES-1:0]     tbl_q, tbl_nx;
    logic                  hit_lo, hit_hi, hit_sel;
    logic [3:0]            dec_code [PAIRS];
    page_t                 dec_pg   [PAGES];
    logic                  chr_forced, chr_set, chr_clr;
    page_t                 cur_pg;

    assign hit_lo   = io_wr && (io_addr == P_RD_LO);
    assign hit_hi   = io_wr && (io_addr == P_RD_HI);
    assign hit_sel  = io_wr && (io_addr == P_ROM_SEL);
    assign kbank_nx = hit_sel ? io_wdata[1] : kbank_q;
    assign f0_src   = hit_lo ? io_wdata : f0_q;

    assign dec_code[0] = f0_src[3:0];
    assign dec_code[1] = f0_src[7:4];
    assign dec_code[2] = io_wdata[3:0];
    assign dec_code[3] = io_wdata[7:4];

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        bankmap_nibble_dec #(
            .PAIR       (g),
            .EXT_FITTED (EXT_RAM_FITTED)
        ) u_dec (
            .code  (dec_code[g]),
            .kbank (kbank_nx),
            .pg_lo (dec_pg[2*g]),
            .pg_hi (dec_pg[2*g+1])
        );
    end

    bankmap_char_fsm u_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (chr_sel_n),
        .forced  (chr_forced),
        .set_evt (chr_set),
        .clr_evt (chr_clr)
    );

    // Port effects first, pin events on top.
    always_comb begin
        tbl_nx = tbl_q;
        if (hit_lo || (hit_sel && io_wdata[0])) begin
            for (int p = 0; p < LO_PAGES; p++) tbl_nx[p] = dec_pg[p];
            if (chr_forced) tbl_nx[3] = mk_page(SRC_CHAR, 3'd0);
        end
        if (hit_sel && !io_wdata[0]) begin
            if (!(tbl_q[2].src == SRC_BASIC && tbl_q[2].seg == 3'd2))
                tbl_nx[2] = mk_page(SRC_VOICE, 3'd0);
            if (!(tbl_q[3].src == SRC_BASIC && tbl_q[3].seg == 3'd3))
                tbl_nx[3] = mk_page(SRC_VOICE, 3'd1);
        end
        if (hit_hi) begin
            for (int p = LO_PAGES; p < PAGES; p++) tbl_nx[p] = dec_pg[p];
        end
        if (chr_set) tbl_nx[3] = mk_page(SRC_CHAR, 3'd0);
        if (chr_clr) begin
            for (int p = 0; p < LO_PAGES; p++) tbl_nx[p] = dec_pg[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f0_q    <= LO_RST;
            f1_q    <= HI_RST;
            kbank_q <= 1'b0;
            for (int p = 0; p < PAGES; p++)
                tbl_q[p] <= (p < LO_PAGES) ? mk_page(SRC_BASIC, SEG_W'(p))
                                           : mk_page(SRC_RAM, SEG_W'(p));
        end else begin
            if (hit_lo) f0_q <= io_wdata;
            if (hit_hi) f1_q <= io_wdata;
            kbank_q <= kbank_nx;
            tbl_q   <= tbl_nx;
        end
    end

    always_comb begin
        if (io_addr == P_RD_LO)      io_rdata = f0_q;
        else if (io_addr == P_RD_HI) io_rdata = f1_q;
        else                         io_rdata = 8'hFF;
    end

    assign cur_pg = tbl_q[mem_addr[ADDR_W-1 -: PAGE_W]];
    assign rd_src = cur_pg.src;
    assign rd_off = {cur_pg.seg, mem_addr[OFF_W-1:0]};

    bankmap_wr_ctrl #(
        .ADDR_W     (ADDR_W),
        .EXT_FITTED (EXT_RAM_FITTED),
        .P_WR_EN    (P_WR_EN)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .mem_addr (mem_addr),
        .mem_wr   (mem_wr),
        .wr_src   (wr_src),
        .wr_off   (wr_off),
        .wr_gate  (wr_gate)
    );

endmodule

// File: rtl/bankmap_mapper_chk.sv
module bankmap_mapper_chk
    import bankmap_pkg::*;
#(
    parameter logic [7:0] P_RD_LO = 8'hF0,
    parameter logic [7:0] P_WR_EN = 8'hF2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic [7:0]  io_addr,
    input logic [7:0]  io_wdata,
    input logic        chr_sel_n,
    input logic        wr_gate,
    input logic [7:0]  f0_q,
    input page_t [7:0] tbl_q
);
    // R13
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_RD_LO) |=> (f0_q == $past(io_wdata)));

    // R7
    wr_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_WR_EN && io_wdata == 8'h00) |=> !wr_gate);

    // R11
    chr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chr_sel_n) |=> (tbl_q[3].src == SRC_CHAR));

    // R12
    chr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chr_sel_n) |=> (tbl_q[3].src != SRC_CHAR));

    // R14
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr && $stable(chr_sel_n)) |=> $stable(tbl_q));

endmodule

bind bankmap_mapper bankmap_mapper_chk #(
    .P_RD_LO (P_RD_LO),
    .P_WR_EN (P_WR_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .chr_sel_n (chr_sel_n),
    .wr_gate   (wr_gate),
    .f0_q      (f0_q),
    .tbl_q     (tbl_q)
);

// File: tb/bankmap_mapper_bench.sv
`timescale 1ns/1ps
module bankmap_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        chr_sel_n = 1'b1;
    logic [15:0] mem_addr = 16'h0000;
    logic        mem_wr = 1'b0;
    logic [3:0]  rd_src, wr_src;
    logic [15:0] rd_off, wr_off;
    logic        wr_gate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bankmap_mapper u_bankmap_mapper (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .chr_sel_n(chr_sel_n),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .rd_src(rd_src), .rd_off(rd_off),
        .wr_src(wr_src), .wr_off(wr_off), .wr_gate(wr_gate)
    );

    // {req, port, data, addr, src, off}
    localparam int NV = 26;
    localparam logic [55:0] VEC [NV] = '{
        {4'd3, 8'hF0, 8'h00, 16'h0123, 4'd0, 16'h0123},  // R3
        {4'd2, 8'hF0, 8'h11, 16'h2345, 4'd1, 16'h2345},  // R2
        {4'd3, 8'hF0, 8'h22, 16'h1000, 4'd2, 16'h1000},  // R3
        {4'd4, 8'hF0, 8'h22, 16'h6001, 4'd3, 16'h2001},  // R4
        {4'd3, 8'hF0, 8'h55, 16'h2004, 4'd1, 16'h2004},  // R3
        {4'd4, 8'hF0, 8'h55, 16'h4004, 4'd3, 16'h0004},  // R4
        {4'd4, 8'hF0, 8'h55, 16'h6004, 4'd1, 16'h6004},  // R4
        {4'd3, 8'hF0, 8'h78, 16'h0010, 4'd5, 16'h0010},  // R3
        {4'd4, 8'hF0, 8'h78, 16'h4010, 4'd4, 16'h0010},  // R4
        {4'd3, 8'hF0, 8'h9A, 16'h2011, 4'd5, 16'h0011},  // R3
        {4'd4, 8'hF0, 8'h9A, 16'h6011, 4'd1, 16'h6011},  // R4
        {4'd3, 8'hF0, 8'hBC, 16'h2020, 4'd4, 16'h0020},  // R3
        {4'd4, 8'hF0, 8'hBC, 16'h6020, 4'd3, 16'h2020},  // R4
        {4'd5, 8'hF0, 8'hDE, 16'h1234, 4'd8, 16'h1234},  // R5
        {4'd5, 8'hF0, 8'hDE, 16'h5234, 4'd7, 16'h5234},  // R5
        {4'd3, 8'hF0, 8'h3F, 16'h0234, 4'd0, 16'h0234},  // R3
        {4'd4, 8'hF0, 8'h3F, 16'h7234, 4'd5, 16'h1234},  // R4
        {4'd3, 8'hF0, 8'h46, 16'h2345, 4'd2, 16'h2345},  // R3
        {4'd4, 8'hF0, 8'h46, 16'h6345, 4'd4, 16'h0345},  // R4
        {4'd3, 8'hF1, 8'h61, 16'hA000, 4'd1, 16'h2000},  // R3
        {4'd4, 8'hF1, 8'h61, 16'hE001, 4'd2, 16'h2001},  // R4
        {4'd4, 8'hF1, 8'h61, 16'hC002, 4'd1, 16'h4002},  // R4
        {4'd3, 8'hF1, 8'hD5, 16'h8003, 4'd2, 16'h0003},  // R3
        {4'd5, 8'hF1, 8'hD5, 16'hE003, 4'd7, 16'hE003},  // R5
        {4'd5, 8'hF1, 8'hE2, 16'hC100, 4'd8, 16'hC100},  // R5
        {4'd2, 8'hF1, 8'hE2, 16'hA100, 4'd2, 16'h2100}   // R2
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = p; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_probe(input string tag, input logic [15:0] a,
                            input logic [3:0] es, input logic [15:0] eo);
        mem_addr = a; mem_wr = 1'b0;
        #1;
        chk({tag, " rd_src"}, 32'(rd_src), 32'(es));
        chk({tag, " rd_off"}, 32'(rd_off), 32'(eo));
    endtask

    task automatic wr_probe(input string tag, input logic [15:0] a, input logic w,
                            input logic [3:0] es, input logic eg);
        mem_addr = a; mem_wr = w;
        #1;
        chk({tag, " wr_src"}, 32'(wr_src), 32'(es));
        chk({tag, " wr_gate"}, 32'(wr_gate), 32'(eg));
        if (eg) chk({tag, " wr_off"}, 32'(wr_off), 32'(a));
        mem_wr = 1'b0;
    endtask

    task automatic port_probe(input string tag, input logic [7:0] p, input logic [7:0] e);
        io_addr = p;
        #1;
        chk(tag, 32'(io_rdata), 32'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        port_probe("R1 F0 reset", 8'hF0, 8'h11);
        port_probe("R1 F1 reset", 8'hF1, 8'hDD);
        port_probe("R13 unmapped", 8'h55, 8'hFF);
        rd_probe("R1 page0", 16'h0000, 4'd1, 16'h0000);
        rd_probe("R1 page3", 16'h6000, 4'd1, 16'h6000);
        rd_probe("R1 page4", 16'h8000, 4'd7, 16'h8000);
        wr_probe("R1 region0", 16'h0000, 1'b1, 4'd0, 1'b0);
        wr_probe("R1 region2", 16'h8000, 1'b1, 4'd7, 1'b1);

        for (int i = 0; i < NV; i++) begin
            io_write(VEC[i][51:44], VEC[i][43:36]);
            rd_probe($sformatf("R%0d vec%0d", VEC[i][55:52], i),
                     VEC[i][35:20], VEC[i][19:16], VEC[i][15:0]);
        end

        port_probe("R13 F0 back", 8'hF0, 8'h46);
        port_probe("R13 F1 back", 8'hF1, 8'hE2);
        port_probe("R13 C2 reads FF", 8'hC2, 8'hFF);

        // kanji half and re-decode
        io_write(8'hC2, 8'h03);
        rd_probe("R10 redecode upper kanji", 16'h2005, 4'd2, 16'h6005);
        rd_probe("R8 old page keeps half", 16'hA100, 4'd2, 16'h2100);
        io_write(8'hF1, 8'hE2);
        rd_probe("R8 rewritten page", 16'hA100, 4'd2, 16'h6100);

        // write enables
        io_write(8'hF2, 8'h19);
        wr_probe("R6 region0 ram", 16'h1000, 1'b1, 4'd7, 1'b1);
        wr_probe("R6 region1 xram", 16'h5000, 1'b1, 4'd8, 1'b1);
        wr_probe("R6 region2 ram", 16'h9000, 1'b1, 4'd7, 1'b1);
        wr_probe("R6 no request", 16'h9000, 1'b0, 4'd7, 1'b0);
        wr_probe("R7 region3 off", 16'hD000, 1'b1, 4'd0, 1'b0);

        // voice overlay
        io_write(8'hF0, 8'h00);
        io_write(8'hC2, 8'h00);
        rd_probe("R9 page2 voice", 16'h4007, 4'd3, 16'h0007);
        rd_probe("R9 page3 voice", 16'h6007, 4'd3, 16'h2007);
        io_write(8'hC2, 8'h01);
        rd_probe("R10 reapply empty", 16'h4000, 4'd0, 16'h0000);
        io_write(8'hF0, 8'h60);
        io_write(8'hC2, 8'h00);
        rd_probe("R9 basic kept", 16'h4008, 4'd1, 16'h4008);
        rd_probe("R9 page3 voice again", 16'h6008, 4'd3, 16'h2008);

        // character ROM pin
        io_write(8'hF0, 8'h11);
        @(negedge clk); chr_sel_n = 1'b0;
        @(negedge clk);
        rd_probe("R11 page3 char", 16'h6100, 4'd6, 16'h0100);
        rd_probe("R11 page2 untouched", 16'h4100, 4'd1, 16'h4100);
        io_write(8'hF0, 8'h00);
        rd_probe("R11 char survives F0", 16'h6100, 4'd6, 16'h0100);
        rd_probe("R11 page2 follows F0", 16'h4100, 4'd0, 16'h0100);
        @(negedge clk); chr_sel_n = 1'b1;
        @(negedge clk);
        rd_probe("R12 release reapply", 16'h6100, 4'd0, 16'h0100);

        // same-cycle ordering
        @(negedge clk);
        io_wr = 1'b1; io_addr = 8'hF0; io_wdata = 8'h11; mem_addr = 16'h0100;
        #1;
        chk("R14 old map same cycle", 32'(rd_src), 32'd0);
        @(negedge clk);
        io_wr = 1'b0;
        #1;
        chk("R14 new map next cycle", 32'(rd_src), 32'd1);
        chk("R14 new offset", 32'(rd_off), 32'h0100);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R14 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule